// File: doc/BRIEF.md
# Cheat code bus patcher

This block sits on the read path between a cartridge and the processor. Software, or a small front end, hands it a cheat code one letter at a time. Each letter stands for a scrambled four-bit value. The block checks the letters and the length of the code. It then gathers a target address, a replacement byte and, for long codes, a compare byte from bits scattered across those values. The decoded result goes into a small table of entries.

On every processor read in the upper half of the address space, the block looks up the address in the table. On a hit it returns the replacement byte instead of the cartridge byte. A short code replaces the byte unconditionally. A long code replaces it only when the cartridge byte equals the compare byte. A clear input empties the table at once.

Top module: `cheat_patch`

## Requirements
- R1: Letters are 8-bit uppercase ASCII and map to nibbles as follows: A=0, P=1, Z=2, L=3, G=4, I=5, T=6, Y=7, E=8, O=9, X=10, U=11, K=12, S=13, V=14, N=15. A code containing any other byte, lowercase included, is rejected: `code_err` pulses and the table is left unchanged.
- R2: A code ends with the symbol that carries `sym_last`. Only codes of 6 or 8 symbols are accepted. On rejection `code_err` is high for exactly the one cycle after the edge that took the last symbol.
- R3: Let nK be the K-th nibble, with n0 the first. The target address is 0x8000 plus a 15-bit offset built from these nibble bits, listed high to low:
  - bits 14..12 take n3[2:0]
  - bit 11 takes n4[3]
  - bits 10..8 take n5[2:0]
  - bit 7 takes n1[3]
  - bits 6..4 take n2[2:0]
  - bit 3 takes n3[3]
  - bits 2..0 take n4[2:0]
- R4: The replacement byte is built from these bits, listed high to low:
  - bit 7 takes n0[3]
  - bits 6..4 take n1[2:0]
  - bit 3 takes n5[3] for a 6-symbol code and n7[3] for an 8-symbol code
  - bits 2..0 take n0[2:0]
- R5: An 8-symbol code has a compare byte built from these bits, listed high to low:
  - bit 7 takes n6[3]
  - bits 6..4 take n7[2:0]
  - bit 3 takes n5[3]
  - bits 2..0 take n6[2:0]

  On a hit, the replacement byte is returned only when `cart_data` equals the compare byte. Otherwise `cart_data` passes through.
- R6: On a read hit for a 6-symbol code, `bus_data` is the replacement byte, whatever `cart_data` holds. Reads are combinational, and a code is usable from the cycle after its last symbol.
- R7: Accepting a code whose address is already in the table overwrites that entry in place. This holds even when the table is full, and it raises no error.
- R8: The table holds ENTRIES entries (4 by default). Accepting a new address when all entries are in use pulses `code_err` and leaves the table unchanged.
- R9: While `rd_en` is low, or `rd_addr[15]` is 0, `bus_data` equals `cart_data`.
- R10: Reset leaves the table empty with `code_err` low. A `clr` cycle empties the table by the next cycle. It also discards a partially entered code, and it cancels a code whose last symbol arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty the table and drop a partial code |
| sym_valid | input | 1 | A symbol is presented this cycle |
| sym_char | input | 8 | ASCII letter of the code |
| sym_last | input | 1 | This symbol ends the code |
| code_err | output | 1 | One-cycle pulse: the code just ended was rejected |
| rd_en | input | 1 | Processor read cycle |
| rd_addr | input | 16 | Processor read address |
| cart_data | input | 8 | Byte from the cartridge |
| bus_data | output | 8 | Byte returned to the processor |

## Verification
The assertions assume that the read inputs are stable around the clock edge, since `bus_data` is combinational and is sampled there. They also assume that `sym_last` is only meaningful together with `sym_valid`. The bench changes every input on the falling edge and raises `sym_last` only with `sym_valid`. The clear check assumes no requirement on what the bench reads in the following cycle, so any address may be applied there. Sweeps over generated codes use only the bench's own decoding formulas to predict the results.

// File: rtl/cheat_patch.sv
module cheat_patch #(
  parameter int ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        sym_valid,
  input  logic [7:0]  sym_char,
  input  logic        sym_last,
  output logic        code_err,
  input  logic        rd_en,
  input  logic [15:0] rd_addr,
  input  logic [7:0]  cart_data,
  output logic [7:0]  bus_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [3:0] nib [8];
  logic [3:0] nx  [8];
  logic [3:0] cnt;
  logic       bad;
  logic [3:0] cur;
  logic       cur_ok;

  always_comb begin
    cur_ok = 1'b1;
    case (sym_char)
      8'h41: cur = 4'h0;
      8'h50: cur = 4'h1;
      8'h5A: cur = 4'h2;
      8'h4C: cur = 4'h3;
      8'h47: cur = 4'h4;
      8'h49: cur = 4'h5;
      8'h54: cur = 4'h6;
      8'h59: cur = 4'h7;
      8'h45: cur = 4'h8;
      8'h4F: cur = 4'h9;
      8'h58: cur = 4'hA;
      8'h55: cur = 4'hB;
      8'h4B: cur = 4'hC;
      8'h53: cur = 4'hD;
      8'h56: cur = 4'hE;
      8'h4E: cur = 4'hF;
      default: begin cur = 4'h0; cur_ok = 1'b0; end
    endcase
  end

  always_comb
    for (int k = 0; k < 8; k++)
      nx[k] = (cnt == 4'(k)) ? cur : nib[k];

  wire [3:0] len    = cnt + 4'd1;
  wire       long_c = (len == 4'd8);
  wire       fmt_ok = !bad && cur_ok && (len == 4'd6 || len == 4'd8);
  wire       ending = sym_valid && sym_last && !clr;

  wire [14:0] new_addr = {nx[3][2:0], nx[4][3], nx[5][2:0], nx[1][3],
                          nx[2][2:0], nx[3][3], nx[4][2:0]};
  wire [7:0]  new_data = {nx[0][3], nx[1][2:0],
                          long_c ? nx[7][3] : nx[5][3], nx[0][2:0]};
  wire [7:0]  new_cmp  = {nx[6][3], nx[7][2:0], nx[5][3], nx[6][2:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (clr || (sym_valid && sym_last)) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (sym_valid) begin
      if (cnt < 4'd9) cnt <= cnt + 4'd1;
      bad <= bad || !cur_ok || (cnt >= 4'd8);
    end

  always_ff @(posedge clk)
    if (sym_valid && !sym_last && !clr)
      for (int k = 0; k < 8; k++) nib[k] <= nx[k];

  logic [ENTRIES-1:0] vld;
  logic [14:0]        t_addr [ENTRIES];
  logic [7:0]         t_data [ENTRIES];
  logic [7:0]         t_cmp  [ENTRIES];
  logic               t_use  [ENTRIES];
  logic [ENTRIES-1:0] dup;
  logic [ENTRIES-1:0] rhit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign dup[i]  = vld[i] && (t_addr[i] == new_addr);
    assign rhit[i] = vld[i] && rd_en && rd_addr[15] && (rd_addr[14:0] == t_addr[i]);
  end

  logic          slot_ok;
  logic [IW-1:0] wsel;

  always_comb begin
    slot_ok = 1'b0;
    wsel    = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (dup[i]) begin slot_ok = 1'b1; wsel = IW'(i); end
    if (dup == '0)
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!vld[i]) begin slot_ok = 1'b1; wsel = IW'(i); end
  end

  wire commit = ending && fmt_ok && slot_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld      <= '0;
      code_err <= 1'b0;
    end else begin
      code_err <= ending && !commit;
      if (clr) vld <= '0;
      else if (commit) vld[wsel] <= 1'b1;
    end

  always_ff @(posedge clk)
    if (commit) begin
      t_addr[wsel] <= new_addr;
      t_data[wsel] <= new_data;
      t_cmp[wsel]  <= new_cmp;
      t_use[wsel]  <= long_c;
    end

  always_comb begin
    bus_data = cart_data;
    for (int i = 0; i < ENTRIES; i++)
      if (rhit[i] && (!t_use[i] || cart_data == t_cmp[i])) bus_data = t_data[i];
  end
endmodule

// File: rtl/cheat_patch_chk.sv
module cheat_patch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        sym_valid,
  input logic        sym_last,
  input logic        code_err,
  input logic        rd_en,
  input logic [15:0] rd_addr,
  input logic [7:0]  cart_data,
  input logic [7:0]  bus_data
);
  // R9
  low_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr[15] |-> bus_data == cart_data);

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> bus_data == cart_data);

  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bus_data == cart_data);

  // R2
  err_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> $past(sym_valid && sym_last));

  // R2
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> !code_err || $past(sym_valid && sym_last));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !code_err);
endmodule

bind cheat_patch cheat_patch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .sym_valid(sym_valid),
  .sym_last(sym_last), .code_err(code_err), .rd_en(rd_en),
  .rd_addr(rd_addr), .cart_data(cart_data), .bus_data(bus_data));

// File: tb/cheat_patch_tb_top.sv
module cheat_patch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym_char = 8'h0;
  logic        sym_last = 1'b0;
  logic        code_err;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = 16'h0;
  logic [7:0]  cart_data = 8'h0;
  logic [7:0]  bus_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cheat_patch #(.ENTRIES(4)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] letter(input logic [3:0] n);
    string s = "APZLGITYEOXUKSVN";
    return s[n];
  endfunction

  function automatic logic [3:0] nb(input logic [31:0] c, input int k);
    return c[4*k +: 4];
  endfunction

  function automatic logic [15:0] e_addr(input logic [31:0] c);
    return 16'h8000 + ((16'(nb(c,3) & 7) << 12) | (16'(nb(c,5) & 7) << 8) |
           (16'(nb(c,4) & 8) << 8) | (16'(nb(c,2) & 7) << 4) |
           (16'(nb(c,1) & 8) << 4) | 16'(nb(c,4) & 7) | 16'(nb(c,3) & 8));
  endfunction

  function automatic logic [7:0] e_data(input logic [31:0] c, input int len);
    logic [3:0] x = (len == 8) ? nb(c,7) : nb(c,5);
    return (8'(nb(c,1) & 7) << 4) | (8'(nb(c,0) & 8) << 4) | 8'(nb(c,0) & 7) | 8'(x & 8);
  endfunction

  function automatic logic [7:0] e_cmp(input logic [31:0] c);
    return (8'(nb(c,7) & 7) << 4) | (8'(nb(c,6) & 8) << 4) | 8'(nb(c,6) & 7) | 8'(nb(c,5) & 8);
  endfunction

  task automatic next_rand(output logic [31:0] v);
    seed = seed * 32'd1103515245 + 32'd12345;
    v = {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endtask

  // bad_pos >= 0 replaces that symbol with bad_ch; returns code_err
  task automatic send(input logic [31:0] c, input int len, input int bad_pos,
                      input logic [7:0] bad_ch, output logic err);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      sym_valid = 1'b1;
      sym_char  = (k == bad_pos) ? bad_ch : letter(nb(c, k % 8));
      sym_last  = (k == len - 1);
      @(posedge clk);
    end
    @(negedge clk);
    sym_valid = 1'b0;
    sym_last  = 1'b0;
    #1 err = code_err;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] cd, input bit en, output logic [7:0] got);
    @(negedge clk);
    rd_en = en; rd_addr = a; cart_data = cd;
    #1 got = bus_data;
  endtask

  task automatic clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c, c2;
    logic [7:0]  g;
    logic        e;
    logic [15:0] a;
    logic [31:0] full [4];

    repeat (3) @(negedge clk);
    #1;
    chk(code_err == 1'b0, "R10 reset err", 16'(code_err), 16'h0);
    rst_n = 1'b1;
    rd(16'hFFFF, 8'h3C, 1'b1, g);
    chk(g == 8'h3C, "R10 reset empty", 16'(g), 16'h3C);

    // R3 R4 R6: sweep of 6-symbol codes
    for (int i = 0; i < 150; i++) begin
      next_rand(c);
      send(c, 6, -1, 8'h0, e);
      chk(e == 1'b0, "R2 6-sym accepted", 16'(e), 16'h0);
      a = e_addr(c);
      rd(a, ~e_data(c, 6), 1'b1, g);
      chk(g == e_data(c, 6), "R3 R4 R6 6-sym hit", 16'(g), 16'(e_data(c, 6)));
      rd(a ^ 16'h0001, 8'h5A, 1'b1, g);
      chk(g == 8'h5A, "R3 neighbour miss", 16'(g), 16'h5A);
      rd(a, 8'h11, 1'b0, g);
      chk(g == 8'h11, "R9 no read cycle", 16'(g), 16'h11);
      clear();
    end

    // R5: sweep of 8-symbol codes
    for (int i = 0; i < 150; i++) begin
      next_rand(c);
      send(c, 8, -1, 8'h0, e);
      chk(e == 1'b0, "R2 8-sym accepted", 16'(e), 16'h0);
      a = e_addr(c);
      rd(a, e_cmp(c), 1'b1, g);
      chk(g == e_data(c, 8), "R5 compare match", 16'(g), 16'(e_data(c, 8)));
      rd(a, e_cmp(c) ^ 8'h24, 1'b1, g);
      chk(g == (e_cmp(c) ^ 8'h24), "R5 compare mismatch", 16'(g), 16'(e_cmp(c) ^ 8'h24));
      clear();
    end

    // R9 low half never patched
    rd(16'h0000, 8'h77, 1'b1, g);
    chk(g == 8'h77, "R9 low address", 16'(g), 16'h77);

    // R1 every letter maps correctly: code with n0 = v, n1 = 0
    for (int v = 0; v < 16; v++) begin
      c = 32'h0000_0000 | 32'(v);
      send(c, 6, -1, 8'h0, e);
      rd(e_addr(c), 8'hFF, 1'b1, g);
      chk(g == e_data(c, 6), "R1 letter value", 16'(g), 16'(e_data(c, 6)));
      clear();
    end

    // R1 invalid symbols
    c = 32'h0000_1234;
    send(c, 6, 2, 8'h42, e);
    chk(e == 1'b1, "R1 invalid letter err", 16'(e), 16'h1);
    rd(e_addr(c), 8'h99, 1'b1, g);
    chk(g == 8'h99, "R1 table unchanged", 16'(g), 16'h99);
    send(c, 6, 0, 8'h61, e);
    chk(e == 1'b1, "R1 lowercase err", 16'(e), 16'h1);

    // R2 bad lengths
    for (int l = 1; l <= 10; l++) begin
      if (l == 6 || l == 8) continue;
      send(32'h0000_5678, l, -1, 8'h0, e);
      chk(e == 1'b1, "R2 bad length", 16'(l), 16'(l));
      @(negedge clk); #1;
      chk(code_err == 1'b0, "R2 err one cycle", 16'(code_err), 16'h0);
    end
    rd(e_addr(32'h0000_5678), 8'h42, 1'b1, g);
    chk(g == 8'h42, "R2 nothing stored", 16'(g), 16'h42);

    // R8 fill table then overflow
    for (int i = 0; i < 4; i++) begin
      full[i] = 32'h0000_0000 | (32'(i) << 12) | 32'h1;
      send(full[i], 6, -1, 8'h0, e);
      chk(e == 1'b0, "R8 fill", 16'(e), 16'h0);
    end
    for (int i = 0; i < 4; i++) begin
      rd(e_addr(full[i]), 8'h00, 1'b1, g);
      chk(g == e_data(full[i], 6), "R8 entries held", 16'(g), 16'(e_data(full[i], 6)));
    end
    c = 32'h0000_7001;
    send(c, 6, -1, 8'h0, e);
    chk(e == 1'b1, "R8 full err", 16'(e), 16'h1);
    rd(e_addr(c), 8'h66, 1'b1, g);
    chk(g == 8'h66, "R8 not stored", 16'(g), 16'h66);

    // R7 same address replaces while full (n0 changes data only)
    c2 = (full[2] & ~32'hF) | 32'h6;
    send(c2, 6, -1, 8'h0, e);
    chk(e == 1'b0, "R7 replace no err", 16'(e), 16'h0);
    rd(e_addr(c2), 8'h00, 1'b1, g);
    chk(g == e_data(c2, 6), "R7 replaced data", 16'(g), 16'(e_data(c2, 6)));
    // R7 replace with 8-symbol code at same address
    c2 = (full[1] & 32'h00FF_FFFF) | 32'hA300_0000;
    send(c2, 8, -1, 8'h0, e);
    chk(e == 1'b0, "R7 replace 8-sym", 16'(e), 16'h0);
    rd(e_addr(c2), e_cmp(c2) ^ 8'h01, 1'b1, g);
    chk(g == (e_cmp(c2) ^ 8'h01), "R7 R5 now conditional", 16'(g), 16'(e_cmp(c2) ^ 8'h01));

    // R10 clear empties table
    clear();
    rd(e_addr(full[0]), 8'h12, 1'b1, g);
    chk(g == 8'h12, "R10 clear empties", 16'(g), 16'h12);

    // R10 clear discards partial code
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sym_valid = 1'b1; sym_char = letter(4'(k + 3)); sym_last = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    sym_valid = 1'b0;
    clear();
    c = 32'h00AB_CDEF;
    send(c, 6, -1, 8'h0, e);
    chk(e == 1'b0, "R10 partial dropped", 16'(e), 16'h0);
    rd(e_addr(c), 8'h00, 1'b1, g);
    chk(g == e_data(c, 6), "R10 code after clear", 16'(g), 16'(e_data(c, 6)));

    // R10 clear in the same cycle as last symbol cancels the code
    clear();
    c = 32'h0012_3456;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sym_valid = 1'b1; sym_char = letter(nb(c, k)); sym_last = (k == 5);
      clr = (k == 5);
      @(posedge clk);
    end
    @(negedge clk);
    sym_valid = 1'b0; sym_last = 1'b0; clr = 1'b0;
    #1 chk(code_err == 1'b0, "R10 cancel no err", 16'(code_err), 16'h0);
    rd(e_addr(c), 8'h3E, 1'b1, g);
    chk(g == 8'h3E, "R10 cancelled code absent", 16'(g), 16'h3E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule